// File: doc/BRIEF.md
# SDLC Transmit Buffer Controller

This block is the transmit side of a bit-oriented synchronous serial channel. A processor or a DMA engine hands it characters one at a time through a single holding register. The block moves each character into a shift register at a character boundary and shifts it out least significant bit first, one bit per `bit_tick` strobe. While the channel is enabled and has nothing to send, it fills the line with flag bytes (0x7E).

The frame ends when the sender stops supplying data. The shifter finishes the last character, and if the holding register is still empty at that moment the block takes an underrun. On underrun it appends the 16-bit frame check sequence, if CRC generation is on, and then a closing flag. After the closing flag it sets an end-of-message status bit and goes back to idle flags. The CRC is CRC-CCITT (x^16+x^12+x^5+1), preset to all ones and taken over every data bit sent. The ones' complement of the remainder is sent, starting with the register's top bit.

Flow control has two styles. In the stall style, the block holds off a processor write while the holding register is occupied. In the request style, it signals a DMA engine whenever the holding register can take a character. A buffer-empty interrupt tells the processor when to write the next character. It stays quiet after enable until the first character has been written.

Top module: `sdlc_txbuf_ctrl`

## Requirements
- R1: `char_len` sets how many low bits of each character are sent: code 2'b00 sends 5, 2'b10 sends 6, 2'b01 sends 7 and 2'b11 sends 8. Higher bits are ignored.
- R2: `tbe_irq` stays low after `tx_en` rises until the first character has been written. From then on it is high exactly when the block is enabled and the holding register is empty.
- R3: With `wait_mode`=1, `cpu_wait` is high while `wr_req` is held against an occupied holding register, and `dma_ready` stays low. The write completes once the register frees.
- R4: With `wait_mode`=0, `dma_ready` is high whenever the block is enabled and the holding register is empty, and `cpu_wait` never rises. A write completes in the cycle it is presented to an empty register.
- R5: Characters leave on `txd` least significant bit first, one bit per `bit_tick`. A character waiting in the holding register at a character boundary is sent right after the previous one, with no gap.
- R6: With `crc_en`=1, an empty holding register at the end of a data character causes an underrun. The block then sends the 16-bit inverted CRC-CCITT remainder (preset 0xFFFF, over all data bits of the frame), top bit first, followed by the flag 0x7E.
- R7: With `crc_en`=0, underrun sends only the closing flag after the last data character.
- R8: While enabled with no frame in progress, `txd` carries back-to-back flags (0x7E, sent from bit 0 upward). While disabled, `txd` is held at 1.
- R9: `eom_flag` rises after the last bit of a closing flag and stays set until an `eom_clr` pulse. If both happen in the same cycle, the set wins.
- R10: Clearing `tx_en` stops shifting at once, empties the holding register and re-arms the first-write suppression of R2. Writes made while disabled are dropped.
- R11: A character written in the very cycle in which the underrun decision is taken does not rescue the frame. The frame is closed with its FCS and flag, and that character opens the next frame directly after the closing flag.
- R12: After reset, `txd`=1 and `tbe_irq`, `dma_ready`, `cpu_wait` and `eom_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| crc_en | input | 1 | Accumulate CRC and append it on underrun |
| char_len | input | 2 | Character length code (see R1) |
| wait_mode | input | 1 | 1: stall style for processor, 0: request style for DMA |
| bit_tick | input | 1 | One-cycle strobe per serial bit time |
| wr_req | input | 1 | Write request for a character |
| wr_data | input | DATA_W | Character to send |
| eom_clr | input | 1 | Clears the end-of-message status |
| cpu_wait | output | 1 | Stall for a write against an occupied register |
| dma_ready | output | 1 | Holding register can take a character |
| tbe_irq | output | 1 | Transmit buffer empty interrupt |
| txd | output | 1 | Serial data out |
| eom_flag | output | 1 | End-of-message / underrun status |

## Verification
The hardest collision is a write and the underrun decision landing in the same clock. The last bit of a lone character is leaving, the holding register is still empty, and the sender writes a new character on exactly that edge. The bench provokes this by counting `bit_tick` strobes from the load of a single-character frame and raising `wr_req` on the eighth. The scoreboard then expects an unbroken bit stream: the first character, its FCS, the closing flag, and immediately after it the second character, its FCS and flag. If a design lets the late write extend the frame, the stream diverges at the first FCS bit. If it loses the write, the stream diverges after the flag.

// File: rtl/txb_pkg.sv
package txb_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FLAG,
        ST_DATA,
        ST_FCS,
        ST_CLOSE
    } txb_state_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;

    // length code to number of bits sent
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        logic [3:0] n;
        case (code)
            2'b00:   n = 4'd5;
            2'b10:   n = 4'd6;
            2'b01:   n = 4'd7;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/txb_crc.sv
module txb_crc #(
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021,
    parameter logic [CW-1:0] INIT = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset_i,
    input  logic          shift_i,
    input  logic          bit_i,
    output logic [CW-1:0] crc_upd_o
);

    typedef struct packed {
        logic [CW-1:0] crc;
    } crc_st_t;

    crc_st_t d, q;

    always_comb begin
        crc_upd_o = {q.crc[CW-2:0], 1'b0} ^ ((q.crc[CW-1] ^ bit_i) ? POLY : '0);
    end

    always_comb begin
        d = q;
        if (preset_i) begin
            d.crc = INIT;
        end else if (shift_i) begin
            d.crc = crc_upd_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.crc <= INIT;
        end else begin
            q <= d;
        end
    end

    a_r6_preset_value: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (q.crc == INIT));

endmodule

// File: rtl/txb_buffer.sv
module txb_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en_i,
    input  logic          wait_mode_i,
    input  logic          wr_req_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          load_i,
    output logic          full_o,
    output logic [DW-1:0] data_o,
    output logic          wait_o,
    output logic          ready_o,
    output logic          irq_o
);

    typedef struct packed {
        logic          full;
        logic          armed;
        logic [DW-1:0] data;
    } buf_st_t;

    buf_st_t d, q;
    logic    accept;

    always_comb begin
        d      = q;
        accept = tx_en_i && wr_req_i && !q.full;
        if (!tx_en_i) begin
            d.full  = 1'b0;
            d.armed = 1'b0;
        end else begin
            if (load_i) begin
                d.full = 1'b0;
            end
            if (accept) begin
                d.full  = 1'b1;
                d.armed = 1'b1;
                d.data  = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign full_o  = q.full;
    assign data_o  = q.data;
    assign wait_o  = tx_en_i && wait_mode_i && wr_req_i && q.full;
    assign ready_o = tx_en_i && !wait_mode_i && !q.full;
    assign irq_o   = tx_en_i && q.armed && !q.full;

    a_r10_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> (!q.full && !irq_o));

    a_r2_quiet_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_i) |-> !irq_o);

    a_r3_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_i && q.full && !load_i) |=> (q.full && $stable(q.data)));

endmodule

// File: rtl/txb_seq.sv
module txb_seq
    import txb_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en_i,
    input  logic          crc_en_i,
    input  logic [1:0]    char_len_i,
    input  logic          bit_tick_i,
    input  logic          eom_clr_i,
    input  logic          full_i,
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] crc_upd_i,
    output logic          load_o,
    output logic          crc_preset_o,
    output logic          crc_shift_o,
    output logic          crc_bit_o,
    output logic          txd_o,
    output logic          eom_o
);

    localparam int SW    = CW;
    localparam int CNT_W = $clog2(SW + 1);

    typedef struct packed {
        txb_state_e       state;
        logic [SW-1:0]    sr;
        logic [CNT_W-1:0] cnt;
        logic             eom;
    } seq_st_t;

    seq_st_t d, q;

    logic             last;
    logic [SW-1:0]    flag_word;
    logic [SW-1:0]    char_word;
    logic [SW-1:0]    fcs_word;
    logic [CW-1:0]    crc_inv;
    logic [CNT_W-1:0] char_cnt;
    txb_state_e       st_q;

    assign crc_inv   = ~crc_upd_i;
    assign flag_word = {{(SW-8){1'b0}}, FLAG_BYTE};
    assign char_word = {{(SW-DW){1'b0}}, data_i};
    assign char_cnt  = CNT_W'(char_bits(char_len_i));
    assign st_q      = q.state;

    // FCS leaves top bit first; shifter sends bit 0 first, so reverse
    for (genvar gi = 0; gi < CW; gi++) begin : g_rev
        assign fcs_word[gi] = crc_inv[CW-1-gi];
    end

    always_comb begin
        d            = q;
        load_o       = 1'b0;
        crc_preset_o = 1'b0;
        crc_shift_o  = 1'b0;
        crc_bit_o    = q.sr[0];
        last         = (q.cnt == CNT_W'(1));
        if (eom_clr_i) begin
            d.eom = 1'b0;
        end
        if (!tx_en_i) begin
            d.state = ST_OFF;
            d.sr    = '0;
            d.cnt   = '0;
        end else if (q.state == ST_OFF) begin
            d.state = ST_FLAG;
            d.sr    = flag_word;
            d.cnt   = CNT_W'(8);
        end else if (bit_tick_i) begin
            crc_shift_o = (q.state == ST_DATA) && crc_en_i;
            if (!last) begin
                d.sr  = q.sr >> 1;
                d.cnt = q.cnt - CNT_W'(1);
            end else begin
                case (q.state)
                    ST_DATA: begin
                        if (full_i) begin
                            load_o = 1'b1;
                            d.sr   = char_word;
                            d.cnt  = char_cnt;
                        end else if (crc_en_i) begin
                            d.state = ST_FCS;
                            d.sr    = fcs_word;
                            d.cnt   = CNT_W'(CW);
                        end else begin
                            d.state = ST_CLOSE;
                            d.sr    = flag_word;
                            d.cnt   = CNT_W'(8);
                        end
                    end
                    ST_FCS: begin
                        d.state = ST_CLOSE;
                        d.sr    = flag_word;
                        d.cnt   = CNT_W'(8);
                    end
                    default: begin
                        if (q.state == ST_CLOSE) begin
                            d.eom = 1'b1;
                        end
                        if (full_i) begin
                            load_o       = 1'b1;
                            crc_preset_o = 1'b1;
                            d.state      = ST_DATA;
                            d.sr         = char_word;
                            d.cnt        = char_cnt;
                        end else begin
                            d.state = ST_FLAG;
                            d.sr    = flag_word;
                            d.cnt   = CNT_W'(8);
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_OFF;
            q.sr    <= '0;
            q.cnt   <= '0;
            q.eom   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign txd_o = (q.state == ST_OFF) ? 1'b1 : q.sr[0];
    assign eom_o = q.eom;

    a_r5_load_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> full_i);

    a_r6_fcs_to_close: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FCS && tx_en_i && bit_tick_i && last) |=> (st_q == ST_CLOSE));

    a_r9_eom_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eom_o) |-> ($past(st_q) == ST_CLOSE));

    a_r8_mark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> (st_q == ST_OFF && txd_o));

endmodule

// File: rtl/sdlc_txbuf_ctrl.sv
module sdlc_txbuf_ctrl #(
    parameter int              DATA_W   = 8,
    parameter int              CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              crc_en,
    input  logic [1:0]        char_len,
    input  logic              wait_mode,
    input  logic              bit_tick,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eom_clr,
    output logic              cpu_wait,
    output logic              dma_ready,
    output logic              tbe_irq,
    output logic              txd,
    output logic              eom_flag
);

    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              load;
    logic              crc_preset;
    logic              crc_shift;
    logic              crc_bit;
    logic [CRC_W-1:0]  crc_upd;

    txb_buffer #(.DW(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en_i    (tx_en),
        .wait_mode_i(wait_mode),
        .wr_req_i   (wr_req),
        .wr_data_i  (wr_data),
        .load_i     (load),
        .full_o     (buf_full),
        .data_o     (buf_data),
        .wait_o     (cpu_wait),
        .ready_o    (dma_ready),
        .irq_o      (tbe_irq)
    );

    txb_crc #(.CW(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (crc_preset),
        .shift_i  (crc_shift),
        .bit_i    (crc_bit),
        .crc_upd_o(crc_upd)
    );

    txb_seq #(.DW(DATA_W), .CW(CRC_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en_i     (tx_en),
        .crc_en_i    (crc_en),
        .char_len_i  (char_len),
        .bit_tick_i  (bit_tick),
        .eom_clr_i   (eom_clr),
        .full_i      (buf_full),
        .data_i      (buf_data),
        .crc_upd_i   (crc_upd),
        .load_o      (load),
        .crc_preset_o(crc_preset),
        .crc_shift_o (crc_shift),
        .crc_bit_o   (crc_bit),
        .txd_o       (txd),
        .eom_o       (eom_flag)
    );

endmodule

// File: tb/sdlc_txbuf_ctrl_tb.sv
module sdlc_txbuf_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       crc_en = 1'b0;
    logic [1:0] char_len = 2'b11;
    logic       wait_mode = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       eom_clr = 1'b0;
    logic       cpu_wait, dma_ready, tbe_irq, txd, eom_flag;

    int n_checks = 0;
    int n_fail = 0;

    logic       exp_q[$];
    string      tag_q[$];
    logic [7:0] frame_bytes[$];
    bit         mon_go = 1'b0;
    logic       prev_irq = 1'b0;
    bit         saw_wait = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sdlc_txbuf_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .crc_en   (crc_en),
        .char_len (char_len),
        .wait_mode(wait_mode),
        .bit_tick (bit_tick),
        .wr_req   (wr_req),
        .wr_data  (wr_data),
        .eom_clr  (eom_clr),
        .cpu_wait (cpu_wait),
        .dma_ready(dma_ready),
        .tbe_irq  (tbe_irq),
        .txd      (txd),
        .eom_flag (eom_flag)
    );

    // bit strobe: one cycle in four, changed just after the rising edge
    initial begin
        int t;
        t = 0;
        forever begin
            @(posedge clk);
            #1;
            t++;
            bit_tick = (t % 4 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_bits(input logic [1:0] c);
        if (c == 2'b00) return 5;
        if (c == 2'b10) return 6;
        if (c == 2'b01) return 7;
        return 8;
    endfunction

    // scoreboard driver side: expected serial stream of one frame
    task automatic push_frame(input logic [1:0] code, input bit use_crc, input string force_tag);
        int          n;
        logic [15:0] crc;
        logic [15:0] fcs;
        logic [7:0]  flag;
        n    = len_bits(code);
        crc  = 16'hFFFF;
        flag = 8'h7E;
        foreach (frame_bytes[j]) begin
            for (int i = 0; i < n; i++) begin
                logic b;
                logic fb;
                b  = frame_bytes[j][i];
                exp_q.push_back(b);
                tag_q.push_back(force_tag != "" ? force_tag : "R1/R5 data");
                fb  = crc[15] ^ b;
                crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        if (use_crc) begin
            fcs = ~crc;
            for (int i = 15; i >= 0; i--) begin
                exp_q.push_back(fcs[i]);
                tag_q.push_back(force_tag != "" ? force_tag : "R6 fcs");
            end
        end
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(flag[i]);
            tag_q.push_back(force_tag != "" ? force_tag : (use_crc ? "R6 flag" : "R7 flag"));
        end
    endtask

    // scoreboard monitor side
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                if (!mon_go && tbe_irq && !prev_irq) mon_go = 1'b1;
                if (mon_go && bit_tick) begin
                    logic  e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(txd === e, tg, int'(txd), int'(e));
                end
            end else begin
                mon_go = 1'b0;
            end
            prev_irq = tbe_irq;
        end
    end

    task automatic wr_byte(input logic [7:0] b);
        if (wait_mode) begin
            @(negedge clk);
            wr_req  = 1'b1;
            wr_data = b;
            #1;
            while (cpu_wait) begin
                saw_wait = 1'b1;
                chk(dma_ready == 1'b0, "R3 no ready in wait mode", int'(dma_ready), 0);
                @(negedge clk);
                #1;
            end
            @(negedge clk);
            wr_req = 1'b0;
        end else begin
            @(negedge clk);
            while (!dma_ready) @(negedge clk);
            wr_req  = 1'b1;
            wr_data = b;
            @(posedge clk);
            #1;
            chk(dma_ready == 1'b0 && cpu_wait == 1'b0, "R4 full after write",
                int'({dma_ready, cpu_wait}), 0);
            @(negedge clk);
            wr_req = 1'b0;
        end
    endtask

    task automatic cap16(output logic [15:0] v);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            while (!bit_tick) @(negedge clk);
            v[i] = txd;
        end
    endtask

    task automatic wait_done();
        int guard;
        guard = 0;
        while (exp_q.size() > 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, "R5 stream complete", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(eom_flag == 1'b1, "R9 eom set", int'(eom_flag), 1);
        eom_clr = 1'b1;
        @(negedge clk);
        eom_clr = 1'b0;
        chk(eom_flag == 1'b0, "R9 eom cleared", int'(eom_flag), 0);
    endtask

    task automatic run_frame(input bit wm, input logic [1:0] code, input bit c_en);
        @(negedge clk);
        wait_mode = wm;
        char_len  = code;
        crc_en    = c_en;
        saw_wait  = 1'b0;
        push_frame(code, c_en, "");
        foreach (frame_bytes[j]) wr_byte(frame_bytes[j]);
        wait_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(txd == 1'b1, "R12 txd", int'(txd), 1);
        chk({tbe_irq, dma_ready, cpu_wait, eom_flag} == 4'b0, "R12 outputs",
            int'({tbe_irq, dma_ready, cpu_wait, eom_flag}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1, "R8 mark while disabled", int'(txd), 1);

        // enable, request style
        wait_mode = 1'b0;
        tx_en     = 1'b1;
        cap16(v);
        chk(v == 16'h7E7E, "R8 idle flags", int'(v), 16'h7E7E);
        chk(tbe_irq == 1'b0, "R2 quiet before first write", int'(tbe_irq), 0);
        chk(dma_ready == 1'b1, "R4 ready when empty", int'(dma_ready), 1);

        frame_bytes = '{8'hA5, 8'h3C, 8'h01};
        run_frame(1'b0, 2'b11, 1'b1);
        chk(tbe_irq == 1'b1, "R2 irq after write, empty", int'(tbe_irq), 1);

        frame_bytes = '{8'h1F, 8'hF3, 8'h0A};
        run_frame(1'b1, 2'b00, 1'b1);
        chk(saw_wait == 1'b1, "R3 wait seen", int'(saw_wait), 1);
        chk(dma_ready == 1'b0, "R3 ready low in wait mode", int'(dma_ready), 0);

        frame_bytes = '{8'hD5, 8'h7F};
        run_frame(1'b0, 2'b01, 1'b0);

        frame_bytes = '{8'hED};
        run_frame(1'b1, 2'b10, 1'b1);

        // R11: write lands on the underrun decision edge
        @(negedge clk);
        wait_mode = 1'b0;
        char_len  = 2'b11;
        crc_en    = 1'b1;
        frame_bytes = '{8'hC3};
        push_frame(2'b11, 1'b1, "R11 first frame");
        frame_bytes = '{8'h96};
        push_frame(2'b11, 1'b1, "R11 second frame");
        wr_byte(8'hC3);
        while (!tbe_irq) @(negedge clk);
        begin
            int k;
            k = 0;
            while (1) begin
                if (bit_tick) begin
                    k++;
                    if (k == 8) break;
                end
                @(negedge clk);
            end
        end
        wr_req  = 1'b1;
        wr_data = 8'h96;
        @(negedge clk);
        wr_req = 1'b0;
        wait_done();

        // R10: disable with a frame in flight
        @(negedge clk);
        wr_byte(8'h11);
        while (!tbe_irq) @(negedge clk);
        wr_req  = 1'b1;
        wr_data = 8'h22;
        @(negedge clk);
        wr_req = 1'b0;
        chk(dma_ready == 1'b0, "R4 occupied", int'(dma_ready), 0);
        tx_en = 1'b0;
        #1;
        chk(tbe_irq == 1'b0 && dma_ready == 1'b0, "R10 outputs drop",
            int'({tbe_irq, dma_ready}), 0);
        @(negedge clk);
        chk(txd == 1'b1, "R10 shifting stopped", int'(txd), 1);
        wr_req  = 1'b1;
        wr_data = 8'h33;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        #1;
        chk(tbe_irq == 1'b0, "R10 re-armed suppression", int'(tbe_irq), 0);
        chk(dma_ready == 1'b1, "R10 buffer emptied", int'(dma_ready), 1);
        cap16(v);
        chk(v == 16'h7E7E, "R10 fresh flags, no stale data", int'(v), 16'h7E7E);
        chk(tbe_irq == 1'b0, "R2 still quiet", int'(tbe_irq), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule